// File: doc/BRIEF.md
# DMA Channel Interrupt Unit with Completion Counter

This block collects eight event pulses from a DMA channel into sticky flags, drives one level-sensitive interrupt line, and counts completed transfers in a small wrapping counter. Software reaches it through a simple register port: a write strobe with a byte offset and write data, and a read data bus that always shows the register selected by the offset.

Each flag is masked by a read-only mask register that comes out of reset with every source masked. Software changes the mask only through two write-only registers: one that unmasks the bits written as 1 and one that masks them. The completion counter shares the status register with the flags; it counts up on every done event and counts down when software clears a done flag that was set, so it tracks completions not yet acknowledged.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the flags read 0, the mask reads 0xFF, the completion count reads 0 and irq_o is low.
- R2: A one-cycle pulse on evt_i bit k sets flag k, seen in status bits 7:0 the cycle after. Bit assignment, bit 0 up: memory done, done, bus error, stream timeout, memory timeout, threshold hit, invalid register access, FIFO overflow.
- R3: A write to the status register (offset 0x0) clears each flag whose write data bit is 1; flags written with 0 keep their value.
- R4: When an event and a status-register clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write to the unmask register (offset 0x4) clears each mask bit written as 1, leaves the others alone, and the register reads back as 0.
- R6: A write to the mask-set register (offset 0x8) sets each mask bit written as 1, leaves the others alone, and the register reads back as 0.
- R7: irq_o is high exactly when some flag is set while its mask bit (offset 0xC, bits 7:0) is clear, updated the cycle after any write or event.
- R8: The completion count, status bits 15:13, rises by one the cycle after each pulse on evt_i bit 1.
- R9: A status write that clears the done flag (bit 1) while it is set lowers the count by one; clearing it while already clear leaves the count unchanged; a done event in the same cycle cancels the decrement.
- R10: The completion count wraps modulo 8 upward and downward.
- R11: Writes to the mask register at 0xC have no effect, and reads of any offset other than 0x0, 0x4, 0x8 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | One-cycle event pulses, one per flag |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 16 | Read data of the register at addr_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check that a pulsed event leaves its flag set, that a clear without a matching event drops the flag, that untouched flags hold, that unmask and mask-set writes reach the mask, that the counter moves by exactly the net of its up and down requests, and that a fully masked unit never raises the interrupt. The register encodings, the readback of zero from the two write-only registers, the fact that clearing an already-clear done flag leaves the count alone, the event-beats-clear ordering seen at the port, and the wrap of the count in both directions are shown only by the bench's scenarios.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NUM_EVT  = 8;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned CNT_LSB  = 13;
  localparam int unsigned REG_W    = CNT_LSB + CNT_W;
  localparam int unsigned ADDR_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFF_STATUS = 4'h0,
    OFF_UNMASK = 4'h4,
    OFF_MASKSET = 4'h8,
    OFF_MASK   = 4'hC
  } reg_off_e;

  typedef enum int unsigned {
    EV_MEM_DONE  = 0,
    EV_DONE      = 1,
    EV_BUS_ERR   = 2,
    EV_TO_STRM   = 3,
    EV_TO_MEM    = 4,
    EV_THRESH    = 5,
    EV_BAD_ACC   = 6,
    EV_FIFO_OVF  = 7
  } evt_bit_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // set has priority over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  assert_evt_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  assert_clr_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] unmask_i,
  input  logic [N-1:0] maskset_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= (mask_q & ~unmask_i) | maskset_i;
  end

  assign mask_o = mask_q;

  assert_unmask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((unmask_i != '0) && (maskset_i == '0)) |=> ((mask_q & $past(unmask_i)) == '0));

  assert_maskset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (maskset_i != '0) |=> ((mask_q & $past(maskset_i)) == $past(maskset_i)));
endmodule

// File: rtl/done_counter.sv
module done_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // natural modulo 2**W wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (inc_i && !dec_i)  cnt_q <= cnt_q + W'(1);
    else if (dec_i && !inc_i)  cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;

  assert_cnt_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i) |=> (cnt_q == W'($past(cnt_q) + W'(1))));

  assert_cnt_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i) |=> (cnt_q == W'($past(cnt_q) - W'(1))));

  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flag, mask, clr, unmask, maskset;
  logic [CNT_W-1:0]   cnt;
  logic               dec;

  assign clr     = (we_i && addr_i == OFF_STATUS)  ? wdata_i : '0;
  assign unmask  = (we_i && addr_i == OFF_UNMASK)  ? wdata_i : '0;
  assign maskset = (we_i && addr_i == OFF_MASKSET) ? wdata_i : '0;
  // count down only when a set done flag is acknowledged
  assign dec     = clr[EV_DONE] & flag[EV_DONE];

  irq_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_i), .clr_i(clr), .flag_o(flag)
  );

  irq_mask_reg #(.N(NUM_EVT)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .unmask_i(unmask), .maskset_i(maskset),
    .mask_o(mask)
  );

  done_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(evt_i[EV_DONE]), .dec_i(dec),
    .cnt_o(cnt)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_STATUS: begin
        rdata_o[NUM_EVT-1:0]       = flag;
        rdata_o[CNT_LSB +: CNT_W]  = cnt;
      end
      OFF_MASK:   rdata_o[NUM_EVT-1:0] = mask;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = |(flag & ~mask);

  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1) |-> !irq_o);

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag != '0));
endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  dma_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  evt;
    logic        we;
    logic [3:0]  addr;
    logic [7:0]  wd;
    logic [15:0] st;
    logic [7:0]  mk;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h02, 1'b0, 4'h0, 8'h00, 16'h2002, 8'hFF, 1'b0}, // R2 R8 done event
    '{8'h80, 1'b0, 4'h0, 8'h00, 16'h2082, 8'hFF, 1'b0}, // R2 overflow event
    '{8'h00, 1'b1, 4'h4, 8'h80, 16'h2082, 8'h7F, 1'b1}, // R5 R7 unmask bit 7
    '{8'h00, 1'b1, 4'h0, 8'h80, 16'h2002, 8'h7F, 1'b0}, // R3 R7 clear bit 7
    '{8'h00, 1'b1, 4'h0, 8'h00, 16'h2002, 8'h7F, 1'b0}, // R3 zeros no effect
    '{8'h00, 1'b1, 4'h0, 8'h02, 16'h0000, 8'h7F, 1'b0}, // R9 clear set done
    '{8'h00, 1'b1, 4'h0, 8'h02, 16'h0000, 8'h7F, 1'b0}, // R9 clear already clear
    '{8'h04, 1'b1, 4'h0, 8'h04, 16'h0004, 8'h7F, 1'b0}, // R4 event beats clear
    '{8'h00, 1'b1, 4'h4, 8'h04, 16'h0004, 8'h7B, 1'b1}, // R5 R7 unmask bit 2
    '{8'h00, 1'b1, 4'h8, 8'h04, 16'h0004, 8'h7F, 1'b0}, // R6 R7 mask bit 2
    '{8'h00, 1'b1, 4'hC, 8'h00, 16'h0004, 8'h7F, 1'b0}, // R11 mask reg read-only
    '{8'h02, 1'b1, 4'h0, 8'h02, 16'h2006, 8'h7F, 1'b0}  // R4 R9 done event vs clear
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic w, input logic [3:0] a,
                      input logic [7:0] d);
    @(negedge clk_i);
    evt_i = e; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    evt_i = '0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic observe(input string req, input logic [15:0] st,
                         input logic [7:0] mk, input logic irq);
    addr_i = 4'h0; #1 check(req, rdata_o, st);
    addr_i = 4'hC; #1 check(req, rdata_o, {8'h00, mk});
    check(req, {15'd0, irq_o}, {15'd0, irq});
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    observe("R1", 16'h0000, 8'hFF, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].evt, VEC[i].we, VEC[i].addr, VEC[i].wd);
      observe($sformatf("vector %0d", i), VEC[i].st, VEC[i].mk, VEC[i].irq);
    end

    // R5 R6 write-only registers read zero; R11 unmapped offset reads zero
    addr_i = 4'h4; #1 check("R5", rdata_o, 16'h0000);
    addr_i = 4'h8; #1 check("R6", rdata_o, 16'h0000);
    addr_i = 4'h2; #1 check("R11", rdata_o, 16'h0000);

    // R10 upward wrap: count 1 plus seven done events gives 0
    for (int k = 0; k < 7; k++) step(8'h02, 1'b0, 4'h0, 8'h00);
    observe("R10", 16'h0006, 8'h7F, 1'b0);

    // R10 downward wrap: clearing the set done flag takes 0 to 7
    step(8'h00, 1'b1, 4'h0, 8'h02);
    observe("R10", 16'hE004, 8'h7F, 1'b0);

    // R7 unmask all then clear all: irq follows
    step(8'h00, 1'b1, 4'h4, 8'hFF);
    observe("R7", 16'hE004, 8'h00, 1'b1);
    step(8'h00, 1'b1, 4'h0, 8'hFF);
    observe("R7", 16'hE000, 8'h00, 1'b0);

    // R1 asynchronous reset restores initial state
    #3 rst_ni = 1'b0;
    #1 observe("R1", 16'h0000, 8'hFF, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule